// File: doc/BRIEF.md
# Dual-Bank Synchronous Clock Divider

The block divides one input clock into two slower clocks. Bank A runs at one half or one quarter of the input rate. Bank B runs at one quarter, one fifth or one sixth. Every output has a 50% duty cycle, and that includes the odd divide-by-5 setting. Both banks advance on the same qualified rising edges of the input clock. After a reset, every rising edge that the two outputs share falls on the same input edge.

An active-low run control is captured on the falling edge of the input clock. The dividers therefore start or stop only while the clock is low, so starting or stopping never produces a shortened pulse. An active-high master reset acts asynchronously. It forces both outputs low and puts the counters in a start state. The first qualified rising edge after reset then drives both outputs high together, which gives every ratio a common phase reference. A new ratio selection is taken up only when the running period of that bank ends.

Top module: `dual_ratio_clkdiv`

## Requirements
- R1: With `sel_a` = 0, `out_a` has a period of 2 input clocks; with `sel_a` = 1 it has a period of 4 input clocks. Each period starts with a high phase that lasts exactly half the period.
- R2: `sel_b` selects the ratio of `out_b`: 2'b00 gives a period of 4 input clocks, 2'b01 gives 6, and both 2'b10 and 2'b11 give 5. Each period starts with a high phase that lasts half the period.
- R3: At divide-by-5, `out_b` stays high for 5 half input periods (2.5 input clocks) and low for the other 5.
- R4: While `rst` is high, both outputs are low no matter what the clock, `en_n` or the selects do, and they go low at once when `rst` rises.
- R5: After reset is released, both outputs rise together on the first qualified rising edge. From then on, every rising edge common to both banks happens on the same input edge.
- R6: `en_n` is sampled on each falling edge of `clk_in`. A low sample lets the dividers advance on the following rising edge and its falling half. A high sample freezes both outputs and counters until a later low sample.
- R7: Toggling `en_n` at any time never produces a high or low pulse on either output shorter than half an input period.
- R8: A change of `sel_a` or `sel_b` takes effect only at the end of the current output period of that bank. The running period completes with the old ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to be divided |
| rst | input | 1 | Asynchronous master reset, active high |
| en_n | input | 1 | Run control, active low, sampled on falling edge |
| sel_a | input | 1 | Bank A ratio select (0: /2, 1: /4) |
| sel_b | input | 2 | Bank B ratio select (00: /4, 01: /6, 1x: /5) |
| out_a | output | 1 | Bank A divided clock |
| out_b | output | 1 | Bank B divided clock |

## Verification
A reference model in the bench tracks each bank's half-period phase and compares both outputs on every half cycle. It is run over all eight select combinations with the run control held active, which separates each ratio's period and high time from its neighbours, tells the odd half-cycle extension apart from an even ratio, and shows whether the banks start in phase. A second pattern drives the run control in a random sequence at a divide-by-5 and a divide-by-6 setting. It checks that outputs freeze instead of advancing and that no runt pulse appears, and a timing monitor measures every output pulse width. A third pattern changes both selects at random points while the dividers run, which shows whether a new ratio cuts the running period short or waits for the period to end.

// File: rtl/dual_ratio_clkdiv.sv
module dual_ratio_clkdiv #(
  parameter int CW = 3
) (
  input  logic       clk_in,
  input  logic       rst,
  input  logic       en_n,
  input  logic       sel_a,
  input  logic [1:0] sel_b,
  output logic       out_a,
  output logic       out_b
);
  localparam logic [CW-1:0] START = '1;
  localparam logic [CW-1:0] ONE   = CW'(1);

  logic          en_q;
  logic [CW-1:0] cnt_a, rat_a, cnt_b, rat_b;
  logic          hi_a, hi_b, dly_b;

  always_ff @(negedge clk_in or posedge rst)
    if (rst) en_q <= 1'b0;
    else     en_q <= ~en_n;

  wire [CW-1:0] want_a = sel_a ? CW'(4) : CW'(2);
  wire [CW-1:0] want_b = (sel_b == 2'b00) ? CW'(4) :
                         (sel_b == 2'b01) ? CW'(6) : CW'(5);

  wire [CW-1:0] inc_a  = cnt_a + ONE;
  wire [CW-1:0] inc_b  = cnt_b + ONE;
  wire          wrap_a = (cnt_a == START) || (cnt_a == rat_a - ONE);
  wire          wrap_b = (cnt_b == START) || (cnt_b == rat_b - ONE);

  always_ff @(posedge clk_in or posedge rst)
    if (rst) begin
      cnt_a <= START;
      rat_a <= CW'(2);
      hi_a  <= 1'b0;
    end else if (en_q) begin
      if (wrap_a) begin
        cnt_a <= '0;
        rat_a <= want_a;
        hi_a  <= 1'b1;
      end else begin
        cnt_a <= inc_a;
        hi_a  <= inc_a < (rat_a >> 1);
      end
    end

  always_ff @(posedge clk_in or posedge rst)
    if (rst) begin
      cnt_b <= START;
      rat_b <= CW'(4);
      hi_b  <= 1'b0;
    end else if (en_q) begin
      if (wrap_b) begin
        cnt_b <= '0;
        rat_b <= want_b;
        hi_b  <= 1'b1;
      end else begin
        cnt_b <= inc_b;
        hi_b  <= inc_b < (rat_b >> 1);
      end
    end

  always_ff @(negedge clk_in or posedge rst)
    if (rst)       dly_b <= 1'b0;
    else if (en_q) dly_b <= hi_b;

  assign out_a = hi_a;
  assign out_b = hi_b | (rat_b[0] & dly_b);
endmodule

module dual_ratio_clkdiv_chk #(
  parameter int CW = 3
) (
  input logic          clk_in,
  input logic          rst,
  input logic          en_q,
  input logic          out_a,
  input logic          out_b,
  input logic [CW-1:0] cnt_a,
  input logic [CW-1:0] cnt_b,
  input logic [CW-1:0] rat_b
);
  p_low_in_reset_r4: assert property (@(posedge clk_in)
    rst && $past(rst) |-> !out_a && !out_b);

  p_a_rise_at_start_r1: assert property (@(posedge clk_in) disable iff (rst)
    $rose(out_a) |-> cnt_a == '0);

  p_b_count_range_r2: assert property (@(posedge clk_in) disable iff (rst)
    (cnt_b < rat_b) || (cnt_b == '1));

  p_div5_high_tail_r3: assert property (@(posedge clk_in) disable iff (rst)
    (rat_b == CW'(5)) && (cnt_b == CW'(1)) |-> out_b);

  p_div5_low_tail_r3: assert property (@(posedge clk_in) disable iff (rst)
    (rat_b == CW'(5)) && (cnt_b == CW'(2)) |-> !out_b);

  p_hold_when_stopped_r6: assert property (@(posedge clk_in) disable iff (rst)
    !$past(en_q) && !en_q |-> $stable(out_a) && $stable(out_b));

  p_ratio_only_at_wrap_r8: assert property (@(posedge clk_in) disable iff (rst)
    (cnt_b != '0) |-> $stable(rat_b));
endmodule

bind dual_ratio_clkdiv dual_ratio_clkdiv_chk #(.CW(CW)) chk_i (
  .clk_in(clk_in), .rst(rst), .en_q(en_q), .out_a(out_a), .out_b(out_b),
  .cnt_a(cnt_a), .cnt_b(cnt_b), .rat_b(rat_b)
);

// File: tb/dual_ratio_clkdiv_tb_top.sv
`timescale 1ns/1ps
module dual_ratio_clkdiv_tb_top;
  logic       clk = 1'b0, rst = 1'b1, en_n = 1'b1, sel_a = 1'b0;
  logic [1:0] sel_b = 2'b00;
  wire        out_a, out_b;

  dual_ratio_clkdiv dut_i (
    .clk_in(clk), .rst(rst), .en_n(en_n), .sel_a(sel_a), .sel_b(sel_b),
    .out_a(out_a), .out_b(out_b)
  );

  always #2 clk = ~clk;

  int    checks = 0, fails = 0;
  bit    done = 0;
  string ph_a = "R1", ph_b = "R2";

  task automatic check_eq(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at %0t: actual %0d expected %0d", tag, what, $time, act, exp);
    end
  endtask

  function automatic int ratio_b(logic [1:0] s);
    return (s == 2'b00) ? 4 : (s == 2'b01) ? 6 : 5;
  endfunction

  bit started = 0, en_m = 0;
  int ca = 0, cb = 0, na = 2, nb = 4, ha = 0, hb = 0;

  always @(posedge clk) begin
    if (rst) started = 0;
    else if (en_m) begin
      if (!started || ca == na - 1) begin ca = 0; na = sel_a ? 4 : 2; end
      else ca++;
      if (!started || cb == nb - 1) begin cb = 0; nb = ratio_b(sel_b); end
      else cb++;
      ha = 2 * ca; hb = 2 * cb;
      started = 1;
    end
  end

  always @(negedge clk) begin
    if (rst) begin started = 0; en_m = 0; end
    else begin
      if (en_m) begin ha = 2 * ca + 1; hb = 2 * cb + 1; end
      en_m = !en_n;
    end
  end

  always @(clk) begin
    #1;
    if (!rst && !done) begin
      check_eq(ph_a, "out_a phase", int'(out_a), int'(started && ha < na));
      check_eq(nb == 5 && ph_b == "R2" ? "R3" : ph_b, "out_b phase",
               int'(out_b), int'(started && hb < nb));
    end
  end

  real last_a = -1.0, last_b = -1.0;
  always @(out_a) begin
    if (!rst && last_a >= 0.0) begin
      checks++;
      if ($realtime - last_a < 1.999) begin
        fails++;
        $display("FAIL R7 out_a pulse: actual %0.3f ns expected >= 2.000 ns", $realtime - last_a);
      end
    end
    last_a = rst ? -1.0 : $realtime;
  end
  always @(out_b) begin
    if (!rst && last_b >= 0.0) begin
      checks++;
      if ($realtime - last_b < 1.999) begin
        fails++;
        $display("FAIL R7 out_b pulse: actual %0.3f ns expected >= 2.000 ns", $realtime - last_b);
      end
    end
    last_b = rst ? -1.0 : $realtime;
  end

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic restart(bit a, logic [1:0] b);
    @(negedge clk); #1;
    rst = 1'b1; sel_a = a; sel_b = b; en_n = 1'b0;
    #0.5;
    check_eq("R4", "out_a at reset", int'(out_a), 0);
    check_eq("R4", "out_b at reset", int'(out_b), 0);
    repeat (2) @(negedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    check_eq("R6", "out_a before enable captured", int'(out_a), 0);
    check_eq("R6", "out_b before enable captured", int'(out_b), 0);
    @(posedge clk); #0.5;
    check_eq("R5", "out_a on first edge", int'(out_a), 1);
    check_eq("R5", "out_b on first edge", int'(out_b), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check_eq("R4", "out_a held in reset", int'(out_a), 0);
    check_eq("R4", "out_b held in reset", int'(out_b), 0);
    en_n = 1'b0; sel_a = 1'b1; sel_b = 2'b10;
    repeat (4) @(posedge clk);
    #1;
    check_eq("R4", "out_a in reset with enable", int'(out_a), 0);
    check_eq("R4", "out_b in reset with enable", int'(out_b), 0);

    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 4; b++) begin
        ph_a = "R1"; ph_b = "R2";
        restart(a[0], b[1:0]);
        repeat (64) @(posedge clk);
      end

    ph_a = "R6"; ph_b = "R6";
    for (int k = 0; k < 2; k++) begin
      restart(1'b1, k == 0 ? 2'b10 : 2'b01);
      for (int i = 0; i < 300; i++) begin
        if ($urandom_range(0, 1) == 0) @(posedge clk); else @(negedge clk);
        #1;
        if ($urandom_range(0, 3) == 0) en_n = ~en_n;
      end
      en_n = 1'b0;
      repeat (20) @(posedge clk);
    end

    ph_a = "R8"; ph_b = "R8";
    restart(1'b0, 2'b00);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk); #1;
      if ($urandom_range(0, 6) == 0) sel_a = 1'($urandom);
      if ($urandom_range(0, 6) == 0) sel_b = 2'($urandom);
    end
    repeat (12) @(posedge clk);
    finish_run();
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end
endmodule